// File: doc/BRIEF.md
# Down-Counting Event Timer with Register Access

This block is one timer channel behind a simple register bus with a select/enable/write access phase. Software writes a 64-bit start value as two 32-bit words and sets a few control bits. After that, a counter steps down by one on every cycle in which the count-enable tick is high. The current count can be read back as two words at any time.

Two count modes are available. In the reloading mode the counter returns to the start value after it reaches zero, so it produces an expiry at a steady period. In the single-event mode it expires once and then stays at zero. Each expiry sets a sticky status flag. Software clears the flag by writing a one to it. The interrupt line is that flag gated by a mask bit.

To reprogram the timer, software first writes zero to the control register. It then writes the low and high start words and writes the control register again with the run bit set. The control register is decoded at one of two offsets, chosen at build time by a parameter.

Top module: `evt_timer`

## Requirements
- R1: After reset all registers read zero, the count is zero and `irq_o` is low.
- R2: The start value is read and written at offset 0x00 (low word) and 0x04 (high word), and the current count is read at 0x08 (low) and 0x0C (high). In the control register, bit 0 is run, bit 1 is single-event mode and bit 2 is unmask. Control bits above bit 2 read as zero.
- R3: With `CTRL_ALT`=0 the control register is decoded at 0x10, and with `CTRL_ALT`=1 it is decoded at 0x1C. The other of the two offsets reads zero, and writes to it change nothing.
- R4: On the clock edge after the run bit goes from 0 to 1, the counter takes the full 64-bit start value. A tick during that cycle is ignored.
- R5: While running, each tick lowers the count by one, and a borrow passes from the low word into the high word. Without a tick, or while run is 0, the count holds its value.
- R6: In reloading mode (bit 1 = 0), a tick that arrives at a count of zero is an expiry and reloads the start value. A start value of N therefore gives one expiry every N+1 ticks.
- R7: In single-event mode (bit 1 = 1) the counter expires once, when a tick arrives at zero. It then holds at zero with no further expiry until run is cleared and set again.
- R8: Every expiry sets the status flag (offset 0x18, bit 0), whatever the mask says. Writing 1 to bit 0 clears the flag. Writing 0 to bit 0 leaves it unchanged.
- R9: `irq_o` is high exactly when the status flag is 1 and the unmask bit is 1.
- R10: If a clear write and an expiry fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Register access select |
| penable_i | input | 1 | Access phase; a write takes effect while this is high |
| pwrite_i | input | 1 | 1 for a write, 0 for a read |
| paddr_i | input | ADDR_W | Byte address of the register |
| pwdata_i | input | DATA_W | Write data |
| prdata_o | output | DATA_W | Read data; combinational from the address while selected |
| tick_i | input | 1 | Count-enable pulse, one step per high cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that every register write uses a two-cycle access, with the select phase first and the enable phase second. They also assume that `tick_i` is a synchronous level sampled on the clock edge. The checks for the reload and load instants assume that software has written the start value before it raises the run bit.

The bench follows the same rules. Writes always go through one access task. Ticks start only after the idle cycle that follows enabling, so none is lost to the load cycle. The exception is the deliberate collision case, which places a tick on the enable phase of a status clear. Randomised start values, modes and tick gaps are kept small, so that every expiry falls within the run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFS_LOAD   = 'h00;
  localparam int unsigned OFS_CUR    = 'h08;
  localparam int unsigned OFS_CTRL_A = 'h10;
  localparam int unsigned OFS_CTRL_B = 'h1C;
  localparam int unsigned OFS_STAT   = 'h18;
  localparam int unsigned WORD_BYTES = 4;

  typedef struct packed {
    logic unmask;
    logic single;
    logic run;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_BITS = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             single_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             done_q;
  logic             rise;
  logic             at_zero;

  assign rise    = run_i & ~run_q;
  assign at_zero = (cnt_q == '0);
  assign expire_o = run_i & ~rise & tick_i & at_zero & (~single_i | ~done_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (rise) begin
        cnt_q  <= load_i;
        done_q <= 1'b0;
      end else if (run_i && tick_i) begin
        if (at_zero) begin
          if (!single_i) cnt_q <= load_i;
          else           done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  p_load_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> cnt_q == $past(load_i));
  p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !single_i) |=> cnt_q == $past(load_i));
  p_single_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && single_i && done_q && !rise) |=> cnt_q == '0);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned ADDR_W   = 5,
  parameter bit          CTRL_ALT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output logic [CNT_W-1:0]  load_o,
  output tmr_ctrl_t         ctrl_o,
  output logic              irq_o
);
  localparam int unsigned N_WORDS = CNT_W / DATA_W;
  localparam int unsigned CTRL_AD = CTRL_ALT ? OFS_CTRL_B : OFS_CTRL_A;

  logic [CNT_W-1:0] load_q;
  tmr_ctrl_t        ctrl_q;
  logic             status_q;
  logic             wr;
  logic             clr_hit;

  assign wr      = psel_i & penable_i & pwrite_i;
  assign clr_hit = wr & (paddr_i == ADDR_W'(OFS_STAT)) & pwdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (wr) begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (paddr_i == ADDR_W'(OFS_LOAD + WORD_BYTES * i))
          load_q[i*DATA_W +: DATA_W] <= pwdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr && paddr_i == ADDR_W'(CTRL_AD))
      ctrl_q <= tmr_ctrl_t'(pwdata_i[CTRL_BITS-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_q <= 1'b0;
    else if (expire_i) status_q <= 1'b1;
    else if (clr_hit)  status_q <= 1'b0;
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (paddr_i == ADDR_W'(OFS_LOAD + WORD_BYTES * i))
          prdata_o = load_q[i*DATA_W +: DATA_W];
        if (paddr_i == ADDR_W'(OFS_CUR + WORD_BYTES * i))
          prdata_o = cnt_i[i*DATA_W +: DATA_W];
      end
      if (paddr_i == ADDR_W'(CTRL_AD)) prdata_o = DATA_W'(ctrl_q);
      if (paddr_i == ADDR_W'(OFS_STAT)) prdata_o = DATA_W'(status_q);
    end
  end

  assign load_o = load_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = status_q & ctrl_q.unmask;

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl_q.unmask);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> status_q);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !expire_i) |=> !status_q);
  p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_i && !pwrite_i && paddr_i == ADDR_W'(CTRL_AD)) |-> prdata_o[DATA_W-1:CTRL_BITS] == '0);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned ADDR_W   = 5,
  parameter bit          CTRL_ALT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic              tick_i,
  output logic              irq_o
);
  logic [CNT_W-1:0] load;
  logic [CNT_W-1:0] cnt;
  logic             expire;
  tmr_ctrl_t        ctrl;

  tmr_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_ALT(CTRL_ALT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
    .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_o(prdata_o),
    .cnt_i(cnt), .expire_i(expire),
    .load_o(load), .ctrl_o(ctrl), .irq_o(irq_o)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .run_i(ctrl.run), .single_i(ctrl.single), .tick_i(tick_i),
    .load_i(load), .cnt_o(cnt), .expire_o(expire)
  );
endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tick = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer u0 (
    .clk(clk), .rst_n(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .tick_i(tick), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit with_tick = 0);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; tick = with_tick;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; tick = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    psel = 0;
  endtask

  task automatic rd_cnt(output logic [63:0] c);
    logic [31:0] lo, hi;
    rd(5'h08, lo); rd(5'h0C, hi);
    c = {hi, lo};
  endtask

  task automatic ticks(input int n, input int max_gap = 0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      repeat ($urandom_range(max_gap, 0)) @(negedge clk);
    end
  endtask

  task automatic arm(input logic [63:0] n, input bit single, input bit unmask);
    wr(5'h10, 0);
    wr(5'h00, n[31:0]);
    wr(5'h04, n[63:32]);
    wr(5'h18, 1);
    wr(5'h10, {29'd0, unmask, single, 1'b1});
    @(negedge clk);
  endtask

  function automatic logic [63:0] exp_cnt(input int n, input bit single, input int t);
    if (single) return (t >= n) ? 64'd0 : 64'(n - t);
    return 64'(n - (t % (n + 1)));
  endfunction

  function automatic logic exp_stat(input int n, input int t);
    return t >= n + 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] c;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(5'h00, d); chk("R1 load lo", d, 0);
    rd(5'h04, d); chk("R1 load hi", d, 0);
    rd_cnt(c);    chk("R1 count", c, 0);
    rd(5'h10, d); chk("R1 ctrl", d, 0);
    rd(5'h18, d); chk("R1 status", d, 0);
    chk("R1 irq", irq, 0);

    // R2 map and control bit width
    wr(5'h00, 32'hA5A5_0F0F); wr(5'h04, 32'h1234_5678);
    rd(5'h00, d); chk("R2 load lo", d, 32'hA5A5_0F0F);
    rd(5'h04, d); chk("R2 load hi", d, 32'h1234_5678);
    wr(5'h10, 32'h6); rd(5'h10, d); chk("R2 ctrl bits", d, 6);
    wr(5'h10, 32'hFFFF_FFF0); rd(5'h10, d); chk("R2 ctrl upper zero", d, 0);

    // R3 alternate offset ignored
    wr(5'h1C, 32'h7);
    rd(5'h10, d); chk("R3 ctrl untouched", d, 0);
    rd(5'h1C, d); chk("R3 alt reads zero", d, 0);
    rd_cnt(c);    chk("R3 not started", c, 0);

    // R4 / R5 64-bit load and borrow
    arm(64'h1_0000_0000, 0, 0);
    rd_cnt(c); chk("R4 loaded", c, 64'h1_0000_0000);
    ticks(1);
    rd_cnt(c); chk("R5 borrow", c, 64'h0_FFFF_FFFF);
    repeat (3) @(negedge clk);
    rd_cnt(c); chk("R5 hold no tick", c, 64'h0_FFFF_FFFF);
    wr(5'h10, 0); ticks(2);
    rd_cnt(c); chk("R5 hold stopped", c, 64'h0_FFFF_FFFF);

    // R6 reloading period
    arm(3, 0, 1);
    ticks(3);
    rd_cnt(c); chk("R6 at zero", c, 0);
    rd(5'h18, d); chk("R6 no early expiry", d, 0);
    ticks(1);
    rd(5'h18, d); chk("R6 expiry", d, 1);
    chk("R9 irq set", irq, 1);
    rd_cnt(c); chk("R6 reload", c, 3);
    wr(5'h18, 1);
    rd(5'h18, d); chk("R8 cleared", d, 0);
    chk("R9 irq cleared", irq, 0);
    ticks(4);
    rd(5'h18, d); chk("R6 second period", d, 1);

    // R8 / R9 masked
    arm(1, 0, 0);
    ticks(2);
    rd(5'h18, d); chk("R8 set while masked", d, 1);
    chk("R9 masked irq", irq, 0);
    wr(5'h18, 0);
    rd(5'h18, d); chk("R8 write zero keeps", d, 1);
    wr(5'h10, 32'h5);
    chk("R9 unmask raises irq", irq, 1);

    // R7 single event
    arm(2, 1, 1);
    ticks(3);
    rd(5'h18, d); chk("R7 expiry", d, 1);
    rd_cnt(c); chk("R7 hold zero", c, 0);
    wr(5'h18, 1);
    ticks(5);
    rd(5'h18, d); chk("R7 no second expiry", d, 0);
    rd_cnt(c); chk("R7 still zero", c, 0);
    arm(2, 1, 1);
    rd_cnt(c); chk("R7 restart loads", c, 2);

    // R10 set beats clear
    arm(0, 0, 1);
    ticks(1);
    rd(5'h18, d); chk("R10 pre set", d, 1);
    wr(5'h18, 1, 1);
    rd(5'h18, d); chk("R10 set wins", d, 1);
    wr(5'h18, 1);
    rd(5'h18, d); chk("R10 later clear", d, 0);

    // Random mix over R6 / R7
    for (int it = 0; it < 24; it++) begin
      int n = $urandom_range(12, 0);
      bit s = 1'($urandom_range(1, 0));
      int t = $urandom_range(30, 1);
      arm(64'(n), s, 1);
      ticks(t, 2);
      rd_cnt(c); chk(s ? "R7 rand count" : "R6 rand count", c, exp_cnt(n, s, t));
      rd(5'h18, d); chk("R8 rand status", d, 32'(exp_stat(n, t)));
      chk("R9 rand irq", irq, exp_stat(n, t));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule